// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block sits next to the special-purpose registers of a small 32-bit RISC pipeline. It carries out every register update that entering an exception needs, and it does so in one clock edge. Each cycle it looks at a synchronous exception request with its cause code and at two interrupt request lines, one external and one from the tick timer. It picks at most one cause and then captures the saved program counter, the saved status word and the error address. It also rewrites the status word, drops the atomic reservation, tells the pipeline to clear its delay-slot and power-management enables, and forms the new fetch address.

The pipeline feeds in the current PC, its delay-slot flag, the live status word, the vector base register and a configuration bit that says whether that base register exists. On the cycle after an entry, `take_o` is high for one cycle and `cause_o` shows the cause that was taken. The pipeline then copies `sr_o` and `pc_o` into its own status register and program counter. The saved registers hold their values until the next entry.

If a synchronous request carries a cause code that no handler exists for, the block makes no update at all and raises `unhandled_o` for one cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On entry, `epcr_o` is loaded with `pc_i`. For cause 12 (system call) it is loaded with `pc_i + 4` instead.
- R2: `eear_o` is loaded with `pc_i` only when the cause is 7 (illegal instruction). Every other entry leaves it unchanged.
- R3: On entry, `esr_o` receives `sr_i` as it stood before the entry. `sr_o` becomes `sr_i` with these changes: bit 0 (supervisor) set, and bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU) and 6 (instruction MMU) cleared.
- R4: On entry, `pwr_clr_o` pulses and `resv_valid_o` is cleared, and clearing wins over a simultaneous `resv_set_i`. Outside an entry, `resv_set_i` sets `resv_valid_o`.
- R5: If `dslot_i` is set on entry, `dflag_clr_o` pulses, `sr_o` bit 13 is set and 4 is subtracted from the value R1 gives for `epcr_o`. If `dslot_i` is clear, bit 13 is cleared and `dflag_clr_o` stays low.
- R6: `pc_o` = cause shifted left by 8. It is also ORed with `evbar_i` when `evbar_en_i` is 1, and ORed with 0xF0000000 when `sr_i` bit 14 is 1.
- R7: A synchronous request with cause 0 or 15 gives a one-cycle pulse on `unhandled_o`. That request changes no output register and takes no interrupt.
- R8: `ext_irq_i` is taken (cause 8) only when `sr_i` bit 2 is set, and `tick_irq_i` is taken (cause 5) only when `sr_i` bit 1 is set. When both qualify, cause 5 is chosen.
- R9: A synchronous request (`exc_req_i`) in the same cycle as a qualifying interrupt is taken, and the interrupt is not taken.
- R10: `take_o` is high for exactly the one cycle after each entry, with `cause_o` holding the taken cause. In every other cycle `cause_o` is 0.
- R11: While reset is active, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 4 | Cause code of the synchronous request |
| ext_irq_i | input | 1 | External interrupt request |
| tick_irq_i | input | 1 | Tick timer interrupt request |
| pc_i | input | 32 | Current PC |
| dslot_i | input | 1 | Faulting instruction sits in a delay slot |
| sr_i | input | 16 | Live status word |
| evbar_i | input | 32 | Vector base register |
| evbar_en_i | input | 1 | Vector base register present |
| resv_set_i | input | 1 | Load-link sets the reservation |
| take_o | output | 1 | Entry occurred on the previous edge |
| cause_o | output | 4 | Taken cause, 0 when none |
| unhandled_o | output | 1 | Unhandled cause code seen |
| epcr_o | output | 32 | Saved PC |
| eear_o | output | 32 | Error effective address |
| esr_o | output | 16 | Saved status word |
| sr_o | output | 16 | Rewritten status word to load |
| pc_o | output | 32 | New fetch PC (vector) |
| dflag_clr_o | output | 1 | Clear the pipeline delay-slot flag |
| pwr_clr_o | output | 1 | Clear doze and sleep enables |
| resv_valid_o | output | 1 | Atomic reservation valid |

## Verification
The random phase draws the request bit, the cause code over its full 4-bit range, both interrupt lines, the status word, the delay-slot flag and both vector-base inputs independently. This mixes synchronous-against-interrupt arbitration and the enable gating with every way the return address is adjusted. Directed cases then separate the mechanisms one at a time. A system call in a delay slot shows whether the +4 and the −4 cancel. An illegal instruction next to other causes shows whether the error address is written selectively. Codes 0 and 15 show that state is frozen. Both interrupt lines asserted under each enable pattern show timer priority and gating, and the vector is formed with base and prefix switched separately.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 4;
  localparam int SR_W    = 16;

  // status word bit positions
  localparam int SR_SUP = 0;
  localparam int SR_TKE = 1;
  localparam int SR_IRE = 2;
  localparam int SR_DMU = 5;
  localparam int SR_IMU = 6;
  localparam int SR_DSE = 13;
  localparam int SR_HPX = 14;

  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t C_NONE    = cause_t'(0);
  localparam cause_t C_TICK    = cause_t'(5);
  localparam cause_t C_ILLEGAL = cause_t'(7);
  localparam cause_t C_EXTINT  = cause_t'(8);
  localparam cause_t C_SYSCALL = cause_t'(12);
  localparam cause_t C_LAST    = cause_t'(14);
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic   exc_req,
  input  cause_t exc_cause,
  input  logic   ext_irq,
  input  logic   tick_irq,
  input  logic   irq_en,
  input  logic   tick_en,
  output logic   take,
  output logic   unhandled,
  output cause_t cause
);
  logic code_ok;

  always_comb begin
    code_ok   = (exc_cause != C_NONE) && (exc_cause <= C_LAST);
    take      = 1'b0;
    unhandled = 1'b0;
    cause     = C_NONE;
    if (exc_req) begin
      take      = code_ok;
      unhandled = !code_ok;
      cause     = code_ok ? exc_cause : C_NONE;
    end else if (tick_irq && tick_en) begin
      take  = 1'b1;
      cause = C_TICK;
    end else if (ext_irq && irq_en) begin
      take  = 1'b1;
      cause = C_EXTINT;
    end
  end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cause_t            cause,
  input  logic [XLEN-1:0]   pc,
  input  logic              dslot,
  input  logic [SR_W-1:0]   sr,
  input  logic [XLEN-1:0]   evbar,
  input  logic              evbar_en,
  output logic [XLEN-1:0]   epcr_nxt,
  output logic              eear_ld,
  output logic [SR_W-1:0]   sr_nxt,
  output logic [XLEN-1:0]   vec
);
  localparam int          VEC_SH    = 8;
  localparam int          PAD_W     = XLEN - CAUSE_W - VEC_SH;
  localparam logic [XLEN-1:0] HI_PREFIX = {4'hF, {(XLEN-4){1'b0}}};
  localparam logic [XLEN-1:0] INSN_B    = XLEN'(4);

  logic [XLEN-1:0] ret_pc;

  always_comb begin
    ret_pc   = (cause == C_SYSCALL) ? pc + INSN_B : pc;
    epcr_nxt = dslot ? ret_pc - INSN_B : ret_pc;
    eear_ld  = (cause == C_ILLEGAL);

    sr_nxt          = sr;
    sr_nxt[SR_SUP]  = 1'b1;
    sr_nxt[SR_TKE]  = 1'b0;
    sr_nxt[SR_IRE]  = 1'b0;
    sr_nxt[SR_DMU]  = 1'b0;
    sr_nxt[SR_IMU]  = 1'b0;
    sr_nxt[SR_DSE]  = dslot;

    vec = {{PAD_W{1'b0}}, cause, {VEC_SH{1'b0}}};
    if (evbar_en)   vec = vec | evbar;
    if (sr[SR_HPX]) vec = vec | HI_PREFIX;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req_i,
  input  logic [3:0]        exc_cause_i,
  input  logic              ext_irq_i,
  input  logic              tick_irq_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              dslot_i,
  input  logic [15:0]       sr_i,
  input  logic [XLEN-1:0]   evbar_i,
  input  logic              evbar_en_i,
  input  logic              resv_set_i,
  output logic              take_o,
  output logic [3:0]        cause_o,
  output logic              unhandled_o,
  output logic [XLEN-1:0]   epcr_o,
  output logic [XLEN-1:0]   eear_o,
  output logic [15:0]       esr_o,
  output logic [15:0]       sr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              dflag_clr_o,
  output logic              pwr_clr_o,
  output logic              resv_valid_o
);
  logic            take_c, unh_c, eear_ld_c;
  cause_t          cause_c;
  logic [XLEN-1:0] epcr_c, vec_c;
  logic [SR_W-1:0] sr_c;

  // next-state values for the registers
  logic            take_n, unh_n, dfc_n, resv_n;
  cause_t          cause_n;
  logic [XLEN-1:0] epcr_n, eear_n, pc_n;
  logic [SR_W-1:0] esr_n, sr_n;

  exc_arbiter u_arb (
    .exc_req   (exc_req_i),
    .exc_cause (exc_cause_i),
    .ext_irq   (ext_irq_i),
    .tick_irq  (tick_irq_i),
    .irq_en    (sr_i[SR_IRE]),
    .tick_en   (sr_i[SR_TKE]),
    .take      (take_c),
    .unhandled (unh_c),
    .cause     (cause_c)
  );

  exc_state_calc #(.XLEN(XLEN)) u_calc (
    .cause    (cause_c),
    .pc       (pc_i),
    .dslot    (dslot_i),
    .sr       (sr_i),
    .evbar    (evbar_i),
    .evbar_en (evbar_en_i),
    .epcr_nxt (epcr_c),
    .eear_ld  (eear_ld_c),
    .sr_nxt   (sr_c),
    .vec      (vec_c)
  );

  always_comb begin
    take_n  = take_c;
    unh_n   = unh_c;
    cause_n = cause_c;
    dfc_n   = take_c && dslot_i;
    epcr_n  = epcr_o;
    eear_n  = eear_o;
    esr_n   = esr_o;
    sr_n    = sr_o;
    pc_n    = pc_o;
    resv_n  = resv_valid_o | resv_set_i;
    if (take_c) begin
      epcr_n = epcr_c;
      esr_n  = sr_i;
      sr_n   = sr_c;
      pc_n   = vec_c;
      resv_n = 1'b0;
      if (eear_ld_c) eear_n = pc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o       <= 1'b0;
      unhandled_o  <= 1'b0;
      cause_o      <= '0;
      dflag_clr_o  <= 1'b0;
      pwr_clr_o    <= 1'b0;
      resv_valid_o <= 1'b0;
      epcr_o       <= '0;
      eear_o       <= '0;
      esr_o        <= '0;
      sr_o         <= '0;
      pc_o         <= '0;
    end else begin
      take_o       <= take_n;
      unhandled_o  <= unh_n;
      cause_o      <= cause_n;
      dflag_clr_o  <= dfc_n;
      pwr_clr_o    <= take_n;
      resv_valid_o <= resv_n;
      if (take_c) begin
        epcr_o <= epcr_n;
        esr_o  <= esr_n;
        sr_o   <= sr_n;
        pc_o   <= pc_n;
      end
      if (take_c && eear_ld_c) eear_o <= eear_n;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req_i,
  input logic [3:0]      exc_cause_i,
  input logic            ext_irq_i,
  input logic            tick_irq_i,
  input logic [XLEN-1:0] pc_i,
  input logic            dslot_i,
  input logic [15:0]     sr_i,
  input logic            evbar_en_i,
  input logic            take_o,
  input logic [3:0]      cause_o,
  input logic            unhandled_o,
  input logic [XLEN-1:0] epcr_o,
  input logic [XLEN-1:0] eear_o,
  input logic [15:0]     esr_o,
  input logic [15:0]     sr_o,
  input logic [XLEN-1:0] pc_o,
  input logic            dflag_clr_o,
  input logic            pwr_clr_o,
  input logic            resv_valid_o
);
  p_esr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> esr_o == $past(sr_i));

  p_sr_rewrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (sr_o[0] && !sr_o[1] && !sr_o[2] && !sr_o[5] && !sr_o[6]));

  p_resv_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (!resv_valid_o && pwr_clr_o));

  p_dslot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (sr_o[13] == $past(dslot_i) && dflag_clr_o == $past(dslot_i)));

  p_plain_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(evbar_en_i) && !$past(sr_i[14]))
      |-> pc_o == {{(XLEN-12){1'b0}}, cause_o, 8'h00});

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled_o |-> (!take_o && $stable(epcr_o) && $stable(eear_o)
                     && $stable(sr_o) && $stable(pc_o)));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(exc_req_i)) |->
      ((cause_o == 4'd5 && $past(tick_irq_i && sr_i[1])) ||
       (cause_o == 4'd8 && $past(ext_irq_i && sr_i[2]) && !$past(tick_irq_i && sr_i[1]))));

  p_sync_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && $past(exc_req_i)) |-> cause_o == $past(exc_cause_i));

  p_idle_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == 4'd0 && !dflag_clr_o && !pwr_clr_o));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_req_i    (exc_req_i),
  .exc_cause_i  (exc_cause_i),
  .ext_irq_i    (ext_irq_i),
  .tick_irq_i   (tick_irq_i),
  .pc_i         (pc_i),
  .dslot_i      (dslot_i),
  .sr_i         (sr_i),
  .evbar_en_i   (evbar_en_i),
  .take_o       (take_o),
  .cause_o      (cause_o),
  .unhandled_o  (unhandled_o),
  .epcr_o       (epcr_o),
  .eear_o       (eear_o),
  .esr_o        (esr_o),
  .sr_o         (sr_o),
  .pc_o         (pc_o),
  .dflag_clr_o  (dflag_clr_o),
  .pwr_clr_o    (pwr_clr_o),
  .resv_valid_o (resv_valid_o)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req_i, ext_irq_i, tick_irq_i, dslot_i, evbar_en_i, resv_set_i;
  logic [3:0]  exc_cause_i;
  logic [31:0] pc_i, evbar_i;
  logic [15:0] sr_i;
  logic        take_o, unhandled_o, dflag_clr_o, pwr_clr_o, resv_valid_o;
  logic [3:0]  cause_o;
  logic [31:0] epcr_o, eear_o, pc_o;
  logic [15:0] esr_o, sr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // expected state
  logic        e_take, e_unh, e_dfc, e_pwr, e_resv;
  logic [3:0]  e_cause;
  logic [31:0] e_epcr, e_eear, e_pc;
  logic [15:0] e_esr, e_sr;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .exc_cause_i(exc_cause_i),
    .ext_irq_i(ext_irq_i), .tick_irq_i(tick_irq_i), .pc_i(pc_i), .dslot_i(dslot_i),
    .sr_i(sr_i), .evbar_i(evbar_i), .evbar_en_i(evbar_en_i), .resv_set_i(resv_set_i),
    .take_o(take_o), .cause_o(cause_o), .unhandled_o(unhandled_o), .epcr_o(epcr_o),
    .eear_o(eear_o), .esr_o(esr_o), .sr_o(sr_o), .pc_o(pc_o),
    .dflag_clr_o(dflag_clr_o), .pwr_clr_o(pwr_clr_o), .resv_valid_o(resv_valid_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: cause selection from the requirements
  function automatic logic [4:0] pick(input logic rq, input logic [3:0] c,
                                      input logic ex, input logic tk,
                                      input logic [15:0] s);
    // returns {taken, cause}; unhandled => taken 0 with cause 15 marker handled separately
    if (rq) return (c != 0 && c != 15) ? {1'b1, c} : 5'd0;      // R9, R7
    if (tk && s[1]) return {1'b1, 4'd5};                          // R8
    if (ex && s[2]) return {1'b1, 4'd8};                          // R8
    return 5'd0;
  endfunction

  task automatic model();
    logic [4:0]  p;
    logic [31:0] ret;
    p       = pick(exc_req_i, exc_cause_i, ext_irq_i, tick_irq_i, sr_i);
    e_take  = p[4];
    e_cause = p[4] ? p[3:0] : 4'd0;
    e_unh   = exc_req_i && (exc_cause_i == 0 || exc_cause_i == 15);
    e_dfc   = p[4] && dslot_i;
    e_pwr   = p[4];
    if (p[4]) begin
      ret = (p[3:0] == 4'd12) ? pc_i + 32'd4 : pc_i;
      if (dslot_i) ret = ret - 32'd4;
      e_epcr = ret;
      if (p[3:0] == 4'd7) e_eear = pc_i;
      e_esr  = sr_i;
      e_sr   = (sr_i & ~16'h0066) | 16'h0001;
      e_sr[13] = dslot_i;
      e_pc   = {20'd0, p[3:0], 8'd0};
      if (evbar_en_i) e_pc = e_pc | evbar_i;
      if (sr_i[14])   e_pc = e_pc | 32'hF000_0000;
      e_resv = 1'b0;
    end else begin
      e_resv = e_resv | resv_set_i;
    end
  endtask

  task automatic compare();
    chk("R10 take", {31'd0, take_o}, {31'd0, e_take});
    chk("R10 cause", {28'd0, cause_o}, {28'd0, e_cause});
    chk("R7 unhandled", {31'd0, unhandled_o}, {31'd0, e_unh});
    chk("R1 epcr", epcr_o, e_epcr);
    chk("R2 eear", eear_o, e_eear);
    chk("R3 esr", {16'd0, esr_o}, {16'd0, e_esr});
    chk("R3 sr", {16'd0, sr_o}, {16'd0, e_sr});
    chk("R6 vector", pc_o, e_pc);
    chk("R5 dflag_clr", {31'd0, dflag_clr_o}, {31'd0, e_dfc});
    chk("R4 pwr_clr", {31'd0, pwr_clr_o}, {31'd0, e_pwr});
    chk("R4 resv", {31'd0, resv_valid_o}, {31'd0, e_resv});
  endtask

  task automatic step(input logic rq, input logic [3:0] c, input logic ex, input logic tk,
                      input logic [31:0] pc, input logic ds, input logic [15:0] s,
                      input logic [31:0] eb, input logic ebe, input logic rs);
    exc_req_i = rq; exc_cause_i = c; ext_irq_i = ex; tick_irq_i = tk;
    pc_i = pc; dslot_i = ds; sr_i = s; evbar_i = eb; evbar_en_i = ebe; resv_set_i = rs;
    model();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    step_idle();
    e_take = 0; e_unh = 0; e_dfc = 0; e_pwr = 0; e_resv = 0; e_cause = 0;
    e_epcr = 0; e_eear = 0; e_pc = 0; e_esr = 0; e_sr = 0;
    repeat (3) @(negedge clk);
    compare(); // R11 reset state
    rst_n = 1'b1;

    // directed corner cases
    step(0, 0, 0, 0, 32'h100, 0, 16'h0000, 0, 0, 1);            // R4 set reservation
    step(1, 4'd12, 0, 0, 32'h2000, 1, 16'h6066, 32'h0, 0, 1);   // R1 R5 syscall in slot, R4 clear wins
    step(1, 4'd7, 0, 0, 32'h3004, 0, 16'h0006, 32'h0, 0, 0);    // R2 illegal loads eear
    step(1, 4'd2, 0, 0, 32'h5000, 0, 16'h0000, 32'h0, 0, 0);    // R2 eear unchanged
    step(1, 4'd0, 1, 1, 32'h7000, 1, 16'h0006, 32'h0, 0, 0);    // R7 code 0
    step(1, 4'd15, 0, 0, 32'h7004, 0, 16'h0000, 32'h0, 0, 0);   // R7 code 15
    step(0, 0, 1, 1, 32'h8000, 0, 16'h0006, 32'h0, 0, 0);       // R8 timer wins
    step(0, 0, 1, 1, 32'h8004, 0, 16'h0004, 32'h0, 0, 0);       // R8 timer gated
    step(0, 0, 1, 1, 32'h8008, 0, 16'h0000, 32'h0, 0, 0);       // R8 both gated
    step(1, 4'd3, 1, 1, 32'h9000, 0, 16'h0006, 32'h0, 0, 0);    // R9 sync first
    step(1, 4'd14, 0, 0, 32'h9100, 0, 16'h4000, 32'h0012_3400, 1, 0); // R6 base and prefix
    step(1, 4'd9, 0, 0, 32'h9200, 0, 16'h0000, 32'h0012_3400, 0, 0);  // R6 base absent
    step(0, 0, 0, 0, 32'h0, 0, 16'h0, 32'h0, 0, 0);             // R10 pulse ends

    for (int i = 0; i < N_RAND; i++) begin
      step($urandom_range(0, 3) == 0, 4'($urandom), $urandom_range(0, 1) == 1,
           $urandom_range(0, 3) == 0, $urandom, $urandom_range(0, 1) == 1,
           16'($urandom), $urandom, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic step_idle();
    exc_req_i = 0; exc_cause_i = 0; ext_irq_i = 0; tick_irq_i = 0; pc_i = 0;
    dslot_i = 0; sr_i = 0; evbar_i = 0; evbar_en_i = 0; resv_set_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule